// File: doc/BRIEF.md
# Cartridge Disk Controller Host Register Interface

This block is the host-facing byte register file of a small cartridge disk controller. The host bus reaches it through a few single-cycle strobes: select a drive, issue a command byte, write a data byte and read a data byte. A status byte is always visible. The block keeps the controller's busy, idle and error flags and a 6-bit head/sector register. When a command is legal, it hands a start request to a neighbouring transfer sequencer. When that sequencer reports completion, the block raises a completion interrupt that cannot be masked.

The data port changes meaning with the idle flag. While the controller is idle, a read returns the current rotational sector from a free-running counter, and a write loads the head/sector register. While the controller is not idle, the same port carries transfer data through a one-byte buffer, and any access sets busy. Every strobe is accepted in the cycle it is presented. There is no back-pressure, so a strobe is never held off and has no ready signal. The start, interrupt and channel-stop outputs are one-cycle pulses.

Top module: `dkc_host_if`

## Requirements
- R1: After reset the status byte is 0x0A, with busy at bit 3 and idle at bit 1. The head/sector register, the held command code, the platter flag, the latched unit and the data buffer are all zero.
- R2: A command byte with bit 3 set is a controller clear. It returns every register to its R1 value in any state and pulses clear_pulse for one cycle.
- R3: A non-clear command is ignored unless the idle bit is set and the drive_busy bit of the latched unit is 0. An ignored command changes no status bit and produces no start pulse.
- R4: An accepted command with code 2 (write, in the low 4 bits) sets the status byte to 0x00. Any other accepted code sets the status byte to busy only (0x08), which clears idle and every error bit.
- R5: Only accepted codes 1 (read), 2 (write) and 3 (read check) pulse start_valid, in the cycle after acceptance. start_op carries the 4-bit code, start_unit carries the latched unit and start_upper carries the latched upper-platter flag. Other codes, such as 5 and 6 (format), are accepted without a start.
- R6: While idle, a data read returns the rotational sector zero-extended to 8 bits. The sector advances by one every ROT_DIV clocks and counts modulo 24.
- R7: While idle, a data write loads the low 6 bits into the head/sector register. While not idle, the head/sector register is left unchanged.
- R8: While not idle, a data write stores the byte in the buffer and sets busy. A data read returns the buffer and sets busy.
- R9: A completion sets idle, clears busy and ORs the reported error bits into status: overrun bit 7, address compare fail bit 6, defective track bit 5, cylinder overflow bit 4, transfer error bit 0. It pulses irq, and it pulses chan_stop in the same cycle when any error bit was reported.
- R10: The examine bit (bit 2) reads 1 exactly when any of status bits 7 to 4 is set. Transfer error alone does not set it.
- R11: A drive select updates the latched unit and upper-platter flag only while idle. The platter flag in start_upper is the one latched when the command was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_valid | input | 1 | Drive select strobe |
| sel_unit | input | 2 | Selected drive number |
| sel_upper | input | 1 | Select addresses the upper (fixed) platter |
| cmd_valid | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Command byte, code in bits 3:0 |
| wr_valid | input | 1 | Data port write strobe |
| wr_byte | input | 8 | Data port write byte |
| rd_strobe | input | 1 | Data port read strobe |
| rd_byte | output | 8 | Data port read value |
| status_byte | output | 8 | Controller status byte |
| drive_busy | input | 4 | Per-drive busy flags |
| hdsc | output | 6 | Head/sector register |
| buf_byte | output | 8 | Transfer data buffer |
| start_valid | output | 1 | Start pulse to the transfer sequencer |
| start_op | output | 4 | Held command code |
| start_unit | output | 2 | Unit latched for the command |
| start_upper | output | 1 | Platter latched for the command |
| done_valid | input | 1 | Completion strobe from the sequencer |
| done_err | input | 5 | Errors {overrun, addr fail, defective, cyl overflow, xfer error} |
| irq | output | 1 | Completion interrupt pulse |
| chan_stop | output | 1 | Tell data channel to stop |
| clear_pulse | output | 1 | Controller clear issued |

## Verification
The assertions assume the sequencer strobes done_valid only while the controller is not idle, and never in the same cycle as a command. Clear-state and head/sector-stability properties rely on these assumptions. The stimulus follows them: every completion comes after an accepted command, and a command is never presented in a completion cycle. Drive-busy and select changes are placed between commands. This lets the ignored-command and ignored-select cases be seen through the next accepted command's start fields.

// File: rtl/dkc_pkg.sv
package dkc_pkg;
  localparam int CMD_W   = 4;
  localparam int CLR_BIT = 3;

  localparam logic [CMD_W-1:0] OP_READ  = 4'd1;
  localparam logic [CMD_W-1:0] OP_WRITE = 4'd2;
  localparam logic [CMD_W-1:0] OP_RCHK  = 4'd3;

  typedef struct packed {
    logic ovr;
    logic acf;
    logic dtk;
    logic cyo;
    logic xfer;
  } err_t;

  function automatic logic op_starts(input logic [CMD_W-1:0] f);
    return (f == OP_READ) || (f == OP_WRITE) || (f == OP_RCHK);
  endfunction
endpackage

// File: rtl/dkc_rotor.sv
module dkc_rotor #(
  parameter int SECTORS = 24,
  parameter int ROT_DIV = 16,
  localparam int SW = $clog2(SECTORS),
  localparam int DW = (ROT_DIV > 1) ? $clog2(ROT_DIV) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [SW-1:0] sector
);
  logic [DW-1:0] div_q;
  wire tick = (div_q == DW'(ROT_DIV - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      sector <= '0;
    end else begin
      div_q <= tick ? '0 : div_q + 1'b1;
      if (tick)
        sector <= (sector == SW'(SECTORS - 1)) ? '0 : sector + 1'b1;
    end
  end
endmodule

// File: rtl/dkc_stat_pack.sv
module dkc_stat_pack
  import dkc_pkg::*;
#(
  parameter int BUSY_BIT = 3,
  parameter int EX_BIT   = 2
) (
  input  err_t       err,
  input  logic       idle,
  input  logic       busy,
  output logic [7:0] sbyte
);
  always_comb begin
    sbyte         = '0;
    sbyte[7]      = err.ovr;
    sbyte[6]      = err.acf;
    sbyte[5]      = err.dtk;
    sbyte[4]      = err.cyo;
    sbyte[1]      = idle;
    sbyte[0]      = err.xfer;
    sbyte[BUSY_BIT] = busy;
    sbyte[EX_BIT] = err.ovr | err.acf | err.dtk | err.cyo;
  end
endmodule

// File: rtl/dkc_host_if.sv
module dkc_host_if
  import dkc_pkg::*;
#(
  parameter int NDRV     = 4,
  parameter int SECTORS  = 24,
  parameter int ROT_DIV  = 16,
  parameter int HS_W     = 6,
  parameter int BUSY_BIT = 3,
  parameter int EX_BIT   = 2,
  localparam int UW = $clog2(NDRV),
  localparam int SW = $clog2(SECTORS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel_valid,
  input  logic [UW-1:0]   sel_unit,
  input  logic            sel_upper,
  input  logic            cmd_valid,
  input  logic [7:0]      cmd_byte,
  input  logic            wr_valid,
  input  logic [7:0]      wr_byte,
  input  logic            rd_strobe,
  output logic [7:0]      rd_byte,
  output logic [7:0]      status_byte,
  input  logic [NDRV-1:0] drive_busy,
  output logic [HS_W-1:0] hdsc,
  output logic [7:0]      buf_byte,
  output logic            start_valid,
  output logic [3:0]      start_op,
  output logic [UW-1:0]   start_unit,
  output logic            start_upper,
  input  logic            done_valid,
  input  logic [4:0]      done_err,
  output logic            irq,
  output logic            chan_stop,
  output logic            clear_pulse
);
  err_t          err_q;
  logic          idle_q, busy_q;
  logic [UW-1:0] unit_q;
  logic          upper_q;
  logic [SW-1:0] sector;

  wire [CMD_W-1:0] code   = cmd_byte[CMD_W-1:0];
  wire             clr    = cmd_valid && cmd_byte[CLR_BIT];
  wire             accept = cmd_valid && !cmd_byte[CLR_BIT] && idle_q && !drive_busy[unit_q];

  dkc_rotor #(.SECTORS(SECTORS), .ROT_DIV(ROT_DIV)) u_rotor (
    .clk(clk), .rst_n(rst_n), .sector(sector)
  );

  dkc_stat_pack #(.BUSY_BIT(BUSY_BIT), .EX_BIT(EX_BIT)) u_pack (
    .err(err_q), .idle(idle_q), .busy(busy_q), .sbyte(status_byte)
  );

  assign rd_byte = idle_q ? 8'(sector) : buf_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q       <= '0;
      idle_q      <= 1'b1;
      busy_q      <= 1'b1;
      unit_q      <= '0;
      upper_q     <= 1'b0;
      hdsc        <= '0;
      buf_byte    <= '0;
      start_op    <= '0;
      start_unit  <= '0;
      start_upper <= 1'b0;
      start_valid <= 1'b0;
      irq         <= 1'b0;
      chan_stop   <= 1'b0;
      clear_pulse <= 1'b0;
    end else if (clr) begin
      err_q       <= '0;
      idle_q      <= 1'b1;
      busy_q      <= 1'b1;
      unit_q      <= '0;
      upper_q     <= 1'b0;
      hdsc        <= '0;
      buf_byte    <= '0;
      start_op    <= '0;
      start_unit  <= '0;
      start_upper <= 1'b0;
      start_valid <= 1'b0;
      irq         <= 1'b0;
      chan_stop   <= 1'b0;
      clear_pulse <= 1'b1;
    end else begin
      start_valid <= 1'b0;
      irq         <= 1'b0;
      chan_stop   <= 1'b0;
      clear_pulse <= 1'b0;

      if (sel_valid && idle_q) begin
        unit_q  <= sel_unit;
        upper_q <= sel_upper;
      end

      if (accept) begin
        start_op    <= code;
        start_unit  <= unit_q;
        start_upper <= upper_q;
        start_valid <= op_starts(code);
        err_q       <= '0;
        idle_q      <= 1'b0;
        busy_q      <= (code != OP_WRITE);
      end

      if (wr_valid) begin
        if (idle_q) hdsc <= wr_byte[HS_W-1:0];
        else begin
          buf_byte <= wr_byte;
          busy_q   <= 1'b1;
        end
      end

      if (rd_strobe && !idle_q) busy_q <= 1'b1;

      if (done_valid) begin
        idle_q    <= 1'b1;
        busy_q    <= 1'b0;
        err_q     <= err_q | err_t'(done_err);
        irq       <= 1'b1;
        chan_stop <= |done_err;
      end
    end
  end
endmodule

// File: rtl/dkc_checker.sv
module dkc_checker #(
  parameter int BUSY_BIT = 3,
  parameter int EX_BIT   = 2,
  parameter int HS_W     = 6
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cmd_valid,
  input logic [7:0]      cmd_byte,
  input logic [7:0]      status_byte,
  input logic            start_valid,
  input logic [3:0]      start_op,
  input logic            irq,
  input logic            chan_stop,
  input logic [HS_W-1:0] hdsc
);
  localparam logic [7:0] RST_STAT = 8'((1 << BUSY_BIT) | 2);

  AST_CLEAR_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmd_valid && cmd_byte[3]) |-> (status_byte == RST_STAT && hdsc == '0)); // R2

  AST_START_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_valid |-> ($past(status_byte[1]) && $past(cmd_valid))); // R3

  AST_START_LEGAL_OP: assert property (@(posedge clk) disable iff (!rst_n)
    start_valid |-> (start_op == 4'd1 || start_op == 4'd2 || start_op == 4'd3)); // R5

  AST_HDSC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (!status_byte[1] && !(cmd_valid && cmd_byte[3])) |=> $stable(hdsc)); // R7

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status_byte[1] && !status_byte[BUSY_BIT])); // R9

  AST_STOP_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    chan_stop |-> irq); // R9

  AST_EX_SUMMARY: assert property (@(posedge clk) disable iff (!rst_n)
    status_byte[EX_BIT] == (|status_byte[7:4])); // R10
endmodule

bind dkc_host_if dkc_checker #(.BUSY_BIT(BUSY_BIT), .EX_BIT(EX_BIT), .HS_W(HS_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
  .status_byte(status_byte), .start_valid(start_valid), .start_op(start_op),
  .irq(irq), .chan_stop(chan_stop), .hdsc(hdsc)
);

// File: tb/sim_dkc_host_if.sv
`timescale 1ns/100ps
module sim_dkc_host_if;
  localparam int ROT_DIV = 16;
  localparam int SECTORS = 24;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sel_valid = 0, sel_upper = 0, cmd_valid = 0, wr_valid = 0, rd_strobe = 0, done_valid = 0;
  logic [1:0] sel_unit = 0;
  logic [7:0] cmd_byte = 0, wr_byte = 0;
  logic [3:0] drive_busy = 0;
  logic [4:0] done_err = 0;
  logic [7:0] rd_byte, status_byte, buf_byte;
  logic [5:0] hdsc;
  logic       start_valid, start_upper, irq, chan_stop, clear_pulse;
  logic [3:0] start_op;
  logic [1:0] start_unit;

  always #2.5 clk = ~clk;

  dkc_host_if #(.ROT_DIV(ROT_DIV), .SECTORS(SECTORS)) u0 (
    .clk(clk), .rst_n(rst_n), .sel_valid(sel_valid), .sel_unit(sel_unit), .sel_upper(sel_upper),
    .cmd_valid(cmd_valid), .cmd_byte(cmd_byte), .wr_valid(wr_valid), .wr_byte(wr_byte),
    .rd_strobe(rd_strobe), .rd_byte(rd_byte), .status_byte(status_byte), .drive_busy(drive_busy),
    .hdsc(hdsc), .buf_byte(buf_byte), .start_valid(start_valid), .start_op(start_op),
    .start_unit(start_unit), .start_upper(start_upper), .done_valid(done_valid), .done_err(done_err),
    .irq(irq), .chan_stop(chan_stop), .clear_pulse(clear_pulse)
  );

  typedef enum int {S_STAT, S_RD, S_HDSC, S_START, S_SV, S_IRQ, S_BUF, S_CLR} sel_e;
  typedef struct {
    sel_e        which;
    logic [15:0] exp;
    string       req;
  } item_t;

  item_t q[$];
  int n_chk = 0, n_bad = 0;

  function automatic logic [15:0] pick(sel_e w);
    case (w)
      S_STAT:  return 16'(status_byte);
      S_RD:    return 16'(rd_byte);
      S_HDSC:  return 16'(hdsc);
      S_START: return 16'({start_valid, start_op, start_unit, start_upper});
      S_SV:    return 16'(start_valid);
      S_IRQ:   return 16'({irq, chan_stop});
      S_BUF:   return 16'(buf_byte);
      default: return 16'(clear_pulse);
    endcase
  endfunction

  task automatic compare(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      compare(it.req, pick(it.which), it.exp);
    end
  end

  task automatic expect_v(sel_e w, logic [15:0] e, string req);
    item_t it;
    it.which = w; it.exp = e; it.req = req;
    q.push_back(it);
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic do_cmd(logic [7:0] b);
    cmd_valid = 1; cmd_byte = b; step(); cmd_valid = 0;
  endtask
  task automatic do_sel(logic [1:0] u, logic up);
    sel_valid = 1; sel_unit = u; sel_upper = up; step(); sel_valid = 0;
  endtask
  task automatic do_wr(logic [7:0] b);
    wr_valid = 1; wr_byte = b; step(); wr_valid = 0;
  endtask
  task automatic do_rd();
    rd_strobe = 1; step(); rd_strobe = 0;
  endtask
  task automatic do_done(logic [4:0] e);
    done_valid = 1; done_err = e; step(); done_valid = 0; done_err = 0;
  endtask

  initial begin
    #(5.0 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] s0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    step();
    // R1 reset state
    expect_v(S_STAT, 16'h0A, "R1 status");
    expect_v(S_HDSC, 16'h00, "R1 hdsc");
    expect_v(S_START, 16'h00, "R1 start fields");
    expect_v(S_BUF, 16'h00, "R1 buffer");
    step();

    // R11 select while idle, R7 head/sector load while idle
    do_sel(2'd1, 1'b1);
    do_wr(8'h7F);
    expect_v(S_HDSC, 16'h3F, "R7 idle hdsc load");
    expect_v(S_STAT, 16'h0A, "R7 status unchanged");
    step();

    // R3 drive busy blocks command
    drive_busy = 4'b0010;
    do_cmd(8'h01);
    expect_v(S_STAT, 16'h0A, "R3 busy drive status");
    expect_v(S_SV, 16'h0, "R3 busy drive no start");
    step();
    drive_busy = 4'b0000;

    // R4/R5 read accepted
    do_cmd(8'h01);
    expect_v(S_STAT, 16'h08, "R4 read busy only");
    expect_v(S_START, 16'h8B, "R5 read start fields");
    step();
    expect_v(S_SV, 16'h0, "R5 start is one pulse");

    // R3 command while not idle ignored
    do_cmd(8'h02);
    expect_v(S_STAT, 16'h08, "R3 not idle status");
    expect_v(S_SV, 16'h0, "R3 not idle no start");

    // R8 data write and read while busy; R7 hdsc held
    do_wr(8'hA5);
    expect_v(S_BUF, 16'hA5, "R8 buffer store");
    expect_v(S_HDSC, 16'h3F, "R7 hdsc held when not idle");
    expect_v(S_RD, 16'hA5, "R8 read returns buffer");
    do_rd();
    expect_v(S_STAT, 16'h08, "R8 busy after read");

    // R11 select while not idle is ignored
    do_sel(2'd2, 1'b0);

    // R9/R10 completion with address compare fail
    do_done(5'b01000);
    expect_v(S_STAT, 16'h46, "R9 R10 done acf");
    expect_v(S_IRQ, 16'b11, "R9 irq and stop");
    step();
    expect_v(S_IRQ, 16'b00, "R9 irq pulse ends");

    // R4 write clears all; R11 unit still 1 upper
    do_cmd(8'h02);
    expect_v(S_STAT, 16'h00, "R4 write clears status");
    expect_v(S_START, 16'h93, "R11 write start fields");
    do_wr(8'h3C);
    expect_v(S_STAT, 16'h08, "R8 write sets busy");
    expect_v(S_BUF, 16'h3C, "R8 buffer second");

    do_done(5'b00000);
    expect_v(S_STAT, 16'h02, "R9 clean done");
    expect_v(S_IRQ, 16'b10, "R9 irq without stop");
    step();

    // R5 format code accepted without start
    do_cmd(8'h05);
    expect_v(S_STAT, 16'h08, "R4 format accepted");
    expect_v(S_SV, 16'h0, "R5 format no start");
    do_done(5'b00001);
    expect_v(S_STAT, 16'h03, "R10 xfer error no examine");
    expect_v(S_IRQ, 16'b11, "R9 xfer error stop");
    step();

    // R11 select unit 0 lower while idle; read check
    do_sel(2'd0, 1'b0);
    do_cmd(8'h03);
    expect_v(S_STAT, 16'h08, "R4 rchk clears errors");
    expect_v(S_START, 16'h98, "R5 rchk start fields");
    do_done(5'b10010);
    expect_v(S_STAT, 16'h96, "R10 ovr cyo examine");
    step();

    // R2 controller clear from busy state
    do_wr(8'h15);
    expect_v(S_HDSC, 16'h15, "R7 hdsc reload");
    do_sel(2'd3, 1'b1);
    do_cmd(8'h01);
    do_cmd(8'h08);
    expect_v(S_STAT, 16'h0A, "R2 clear status");
    expect_v(S_HDSC, 16'h00, "R2 clear hdsc");
    expect_v(S_CLR, 16'h1, "R2 clear pulse");
    expect_v(S_START, 16'h00, "R2 clear start fields");
    step();
    do_cmd(8'h01);
    expect_v(S_START, 16'h88, "R2 unit and platter cleared");
    expect_v(S_RD, 16'h00, "R2 buffer cleared");
    do_done(5'b00000);
    step();

    // R6 rotational sector while idle
    @(negedge clk);
    s0 = rd_byte;
    compare("R6 sector range", 16'(s0 < 8'(SECTORS)), 16'h1);
    repeat (5 * ROT_DIV) @(negedge clk);
    compare("R6 sector advance", 16'(rd_byte), 16'((s0 + 5) % SECTORS));
    repeat (30 * ROT_DIV) @(negedge clk);
    compare("R6 sector wrap", 16'(rd_byte), 16'((s0 + 35) % SECTORS));

    step();
    step();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule